// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind the command decoder of a serial memory slave. Once a write command and its start address have been accepted, the decoder hands over each complete data byte. The block collects those bytes in a one-page buffer. The write offset advances inside the page only, so a long burst wraps around and replaces bytes already buffered. The page part of the address never changes.

When chip select is released, the decoder reports whether the bit count ended exactly on a byte boundary. If it did and at least one byte arrived, the block starts a self-timed program cycle. During that cycle it walks the page buffer, asks the protection logic about each target address, and writes every unprotected byte into the array. It then stays busy for a parameterised number of clocks. At the end it raises a one-clock request to clear the write-enable latch. No erase step is modelled.

Top module: `page_write_seq`

## Requirements
- R1: After reset `busy`, `mem_we` and `wel_clr` are all 0.
- R2: A `start_vld` pulse opens a write session only when `wel` is 1 and `busy` is 0. Without an open session, `byte_vld` and `cs_rise` cause no array write and no busy period.
- R3: The session's page is `start_addr[AW-1:PW]` and its first offset is `start_addr[PW-1:0]`, with PW = log2(PAGE_BYTES). Each `byte_vld` stores `byte_data` at the current offset and then adds 1 to the offset modulo PAGE_BYTES. The page bits never change.
- R4: A byte stored at an offset that already holds a byte from the same session replaces it. Only the latest value is programmed.
- R5: A `cs_rise` with `cs_aligned`=1 in a session that holds at least one byte starts a program cycle. `busy` is 1 from the clock after `cs_rise`.
- R6: A `cs_rise` with `cs_aligned`=0, or in a session with no bytes, closes the session with no write and no busy period.
- R7: The program cycle visits offsets 0 to PAGE_BYTES-1 in ascending order, one per clock. It pulses `mem_we` with `mem_addr`={page, offset} and the buffered byte, only for offsets written in the session.
- R8: `chk_addr` presents the address being visited. A byte is not written when `chk_prot` is 1 in that clock.
- R9: `busy` stays 1 for exactly PAGE_BYTES + PROG_CYCLES clocks. `wel_clr` is a single-clock pulse in the last of them.
- R10: While `busy` is 1, the inputs `start_vld`, `byte_vld` and `cs_rise` have no effect, and no session exists once the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wel | input | 1 | Current write-enable latch state |
| start_vld | input | 1 | Write command and address accepted |
| start_addr | input | AW | Start address of the write |
| byte_vld | input | 1 | A complete data byte is available |
| byte_data | input | 8 | The data byte |
| cs_rise | input | 1 | Chip select went inactive |
| cs_aligned | input | 1 | Bit count was a whole number of bytes at `cs_rise` |
| chk_addr | output | AW | Address offered to the protection check |
| chk_prot | input | 1 | Address in `chk_addr` is protected |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Request to clear the write-enable latch |

## Verification
The bench uses AW=13 and PAGE_BYTES=32, which match a 64-kbit array with 32-byte pages. PROG_CYCLES is cut to 20 so that every busy window can be counted exactly and several program cycles fit in a short run. A protection threshold set in the middle of a page makes the block skip half of a full page. Bursts start near the top of a page and run past 32 bytes, so the wrap inside the page and the overwrite of earlier bytes are both exercised against the scoreboard.

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int AW          = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wel,
  input  logic          start_vld,
  input  logic [AW-1:0] start_addr,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          cs_rise,
  input  logic          cs_aligned,
  output logic [AW-1:0] chk_addr,
  input  logic          chk_prot,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          busy,
  output logic          wel_clr
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG, S_WAIT} state_t;

  state_t                 state;
  logic [AW-PW-1:0]       page;
  logic [PW-1:0]          ofs;
  logic [PW-1:0]          idx;
  logic [PAGE_BYTES-1:0]  mask;
  logic [CW-1:0]          cnt;
  logic [7:0]             pbuf [PAGE_BYTES];

  assign chk_addr  = {page, idx};
  assign mem_addr  = chk_addr;
  assign mem_wdata = pbuf[idx];
  assign mem_we    = (state == S_PROG) && mask[idx] && !chk_prot;
  assign busy      = (state == S_PROG) || (state == S_WAIT);
  assign wel_clr   = (state == S_WAIT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      page  <= '0;
      ofs   <= '0;
      idx   <= '0;
      mask  <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_vld && wel) begin
          state <= S_LOAD;
          page  <= start_addr[AW-1:PW];
          ofs   <= start_addr[PW-1:0];
          mask  <= '0;
        end
        S_LOAD: if (cs_rise) begin
          idx   <= '0;
          state <= (cs_aligned && |mask) ? S_PROG : S_IDLE;
        end else if (byte_vld) begin
          mask[ofs] <= 1'b1;
          ofs       <= ofs + PW'(1);
        end
        S_PROG: begin
          idx <= idx + PW'(1);
          if (idx == PW'(PAGE_BYTES - 1)) begin
            state <= S_WAIT;
            cnt   <= CW'(PROG_CYCLES - 1);
          end
        end
        S_WAIT: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (state == S_LOAD && !cs_rise && byte_vld) pbuf[ofs] <= byte_data;

endmodule

// File: rtl/page_write_seq_chk.sv
module page_write_seq_chk #(
  parameter int AW         = 13,
  parameter int PAGE_BYTES = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          chk_prot,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          wel_clr
);
  localparam int PW = $clog2(PAGE_BYTES);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  // R7
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R8
  prot_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !chk_prot);

  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW])));

  // R9
  welclr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel_clr) |=> busy);
endmodule

bind page_write_seq page_write_seq_chk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .chk_prot(chk_prot),
  .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy), .wel_clr(wel_clr)
);

// File: tb/tb_page_write_seq.sv
module tb_page_write_seq;
  localparam int AW = 13;
  localparam int PB = 32;
  localparam int PC = 20;
  localparam int PW = $clog2(PB);

  logic clk = 0, rst_n = 0;
  logic wel = 0, start_vld = 0, byte_vld = 0, cs_rise = 0, cs_aligned = 0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic [AW-1:0] chk_addr, mem_addr;
  logic [7:0] mem_wdata;
  logic chk_prot, mem_we, busy, wel_clr;
  logic [AW:0] prot_lo = (AW+1)'(1 << AW);

  int checks = 0, errors = 0, busy_cnt = 0, wclr_cnt = 0;
  logic [AW+7:0] expq[$];

  logic m_active;
  logic [AW-PW-1:0] m_page;
  logic [PW-1:0] m_ofs;
  logic [7:0] m_buf [PB];
  logic [PB-1:0] m_mask;

  always #10 clk = ~clk;

  assign chk_prot = {1'b0, chk_addr} >= prot_lo;

  page_write_seq #(.AW(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (wel_clr) wclr_cnt++;
    if (mem_we) begin
      if (expq.size() == 0) chk(0, "R7 unexpected write", int'({mem_addr, mem_wdata}), 0);
      else begin
        logic [AW+7:0] e;
        e = expq.pop_front();
        chk({mem_addr, mem_wdata} == e, "R7 write addr/data", int'({mem_addr, mem_wdata}), int'(e));
      end
    end
  end

  task automatic do_start(input logic [AW-1:0] a, input logic w);
    @(posedge clk); #1;
    start_vld = 1; start_addr = a; wel = w;
    @(posedge clk); #1;
    start_vld = 0;
    m_active = w; m_page = a[AW-1:PW]; m_ofs = a[PW-1:0]; m_mask = '0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(posedge clk); #1;
    byte_vld = 1; byte_data = d;
    @(posedge clk); #1;
    byte_vld = 0;
    if (m_active) begin
      m_buf[m_ofs] = d; m_mask[m_ofs] = 1; m_ofs = m_ofs + PW'(1);
    end
  endtask

  task automatic do_finish(input logic al, input string req);
    bit go;
    go = m_active && al && (m_mask != 0);
    if (go)
      for (int i = 0; i < PB; i++) begin
        logic [AW-1:0] a;
        a = {m_page, PW'(i)};
        if (m_mask[i] && !({1'b0, a} >= prot_lo)) expq.push_back({a, m_buf[i]});
      end
    m_active = 0;
    busy_cnt = 0; wclr_cnt = 0;
    @(posedge clk); #1;
    cs_rise = 1; cs_aligned = al;
    @(posedge clk); #1;
    cs_rise = 0;
    @(negedge clk); #1;
    chk(busy == go, {req, " busy start"}, busy, go);
  endtask

  task automatic wait_done(input bit go, input string req);
    int g = 0;
    if (go) begin
      while (busy && g < 2000) begin @(negedge clk); g++; end
      #1;
      chk(busy_cnt == PB + PC, "R9 busy length", busy_cnt, PB + PC);
      chk(wclr_cnt == 1, "R9 wel_clr pulses", wclr_cnt, 1);
    end else begin
      repeat (PB + 4) @(negedge clk);
      #1;
      chk(busy_cnt == 0, {req, " no busy"}, busy_cnt, 0);
      chk(wclr_cnt == 0, {req, " no wel_clr"}, wclr_cnt, 0);
    end
    chk(expq.size() == 0, {req, " pending writes"}, expq.size(), 0);
  endtask

  initial begin
    #(100000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_active = 0; m_mask = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    // R1
    chk(!busy && !mem_we && !wel_clr, "R1 reset outputs", {busy, mem_we, wel_clr}, 0);

    // R5 R7 single byte
    do_start(13'h045, 1); do_byte(8'hA5);
    do_finish(1, "R5"); wait_done(1, "R5");

    // R3 wrap inside the page, page bits held
    do_start({8'h05, 5'd30}, 1);
    for (int i = 0; i < 4; i++) do_byte(8'h10 + 8'(i));
    do_finish(1, "R3"); wait_done(1, "R3");

    // R4 overwrite after more than a page
    do_start({8'h0C, 5'd0}, 1);
    for (int i = 0; i < PB + 2; i++) do_byte(8'(i * 3 + 1));
    do_finish(1, "R4"); wait_done(1, "R4");

    // R2 latch clear
    do_start(13'h100, 0); do_byte(8'h77); do_byte(8'h78);
    do_finish(1, "R2"); wait_done(0, "R2");

    // R6 misaligned, then empty session
    do_start(13'h200, 1); do_byte(8'h55);
    do_finish(0, "R6 misaligned"); wait_done(0, "R6");
    do_start(13'h220, 1);
    do_finish(1, "R6 empty"); wait_done(0, "R6");

    // R8 upper half of page protected
    prot_lo = {1'b0, 8'h40, 5'd16};
    do_start({8'h40, 5'd0}, 1);
    for (int i = 0; i < PB; i++) do_byte(8'hC0 ^ 8'(i));
    do_finish(1, "R8"); wait_done(1, "R8");
    prot_lo = (AW+1)'(1 << AW);

    // R10 traffic during busy is ignored
    do_start(13'h300, 1); do_byte(8'h9E);
    do_finish(1, "R10");
    @(posedge clk); #1; start_vld = 1; start_addr = 13'h0400; wel = 1;
    @(posedge clk); #1; start_vld = 0; byte_vld = 1; byte_data = 8'hEE;
    @(posedge clk); #1; byte_vld = 0; cs_rise = 1; cs_aligned = 1;
    @(posedge clk); #1; cs_rise = 0;
    wait_done(1, "R10");
    do_byte(8'hEF);
    do_finish(1, "R10 no session"); wait_done(0, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule